// File: doc/BRIEF.md
# Row-Sequential Binary Morphology Engine

This block applies one step of binary morphology to a small one-bit-per-pixel image held in an internal flag store. It can shrink the image (erosion) or grow it (dilation), using the pixel and its four orthogonal neighbours. The image is processed row by row, and every column of the image is handled in parallel. Each column keeps a three-row sliding window of flags: the row above, the current row and the row below. A column takes its horizontal neighbours from the current-row window bits of the columns on either side. The new value of each row is written back in place, in the same clock as the next row is fetched. No second frame buffer is needed, because the window keeps the values from before the pass.

The image is loaded one row per clock through a row-write port, and any row can be viewed at any time through a combinational peek port. A one-cycle start request captures the operation select and begins a pass. The pass takes two window-fill clocks, then writes one row per clock. A one-cycle done pulse follows the last write. Repeated passes give repeated shrink or expand steps.

Top module: `morphEngine`

## Requirements
- R1: After reset the engine is idle (`busy` = 0, `passDone` = 0) and every image row reads back as all zeros.
- R2: While idle, `loadEn` = 1 writes `loadData` into row `loadRow` at the clock edge. `peekData` always shows row `peekRow` combinationally, with bit c holding column c.
- R3: With `opExpand` = 0 captured at start, a pixel's new value is 1 only if the pixel itself and all four of its orthogonal neighbours are 1.
- R4: With `opExpand` = 1 captured at start, a pixel's new value is 1 if the pixel itself or any of its four orthogonal neighbours is 1.
- R5: Neighbours that fall outside the image (row -1, row ROWS, column -1, column COLS) are read as 0 for both operations.
- R6: Every new value is computed only from image values as they stood when the pass started, even though rows above have already been rewritten.
- R7: A start request accepted at clock edge E0 makes `busy` high for exactly ROWS+2 cycles. Row r takes its new value at edge E0+r+3, and no other row changes at that edge.
- R8: `passDone` is high for exactly one cycle, starting at the edge that writes the last row, and `busy` is 0 while it is high.
- R9: A start request that arrives while `busy` is 1 has no effect on the running pass or on its timing.
- R10: A row load requested while `busy` is 1 is ignored, and the image is left as the pass makes it.
- R11: The operation is taken from `opExpand` at the accepted start. Changes to `opExpand` during the pass have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a pass; accepted only while idle |
| opExpand | input | 1 | 1 = expand (dilation), 0 = shrink (erosion); sampled at start |
| loadEn | input | 1 | Write `loadData` into row `loadRow` while idle |
| loadRow | input | $clog2(ROWS) | Row index for loading |
| loadData | input | COLS | Row contents to load, bit c = column c |
| peekRow | input | $clog2(ROWS) | Row index to view |
| peekData | output | COLS | Current contents of row `peekRow` |
| busy | output | 1 | A pass is in progress |
| passDone | output | 1 | One-cycle pulse after the last row of a pass is written |

## Verification
The bench sweeps the peek row every cycle during each pass, so it sees exactly when each row changes. A design that writes one cycle early or late, or writes to the wrong row, shows a mismatch at that cycle. Dilating a single pixel shows whether the pass reads back rows it has already rewritten: a design that does so spreads the pixel diagonally into the rows below. An all-ones image and a pixel in the corner test the edges of the image: if an outside neighbour were read as 1, erosion would leave the border intact. Other cases inject a start, a row load and an operation change in the middle of a pass. A design that honours any of these disturbs the image or the timing of `busy` and `passDone`.

// File: rtl/morphPkg.sv
package morphPkg;

  typedef enum logic {
    OP_SHRINK = 1'b0,
    OP_EXPAND = 1'b1
  } morphOpE;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic winClear;   // zero all window rows before a pass
    logic winShift;   // advance the window by one row
    logic fillValid;  // lower window row takes an image row (else zero)
    logic rowWrite;   // write the computed row back to the store
  } morphStrobeT;

endpackage

// File: rtl/morphCtrl.sv
module morphCtrl
  import morphPkg::*;
#(
  parameter int ROWS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(ROWS + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  morphOpE       opSel,
  output morphStrobeT   strobe,
  output logic [RW-1:0] rdRow,
  output logic [RW-1:0] wrRow,
  output logic          busy,
  output logic          passDone,
  output morphOpE       opLatched
);

  localparam logic [CW-1:0] LAST_STEP = CW'(ROWS + 1);
  localparam logic [CW-1:0] FILL_STEPS = CW'(2);
  localparam logic [CW-1:0] ROW_LIMIT = CW'(ROWS);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlStateE;

  ctrlStateE   state;
  logic [CW-1:0] stepCnt;
  logic [CW-1:0] wrIdx;
  logic        doneQ;
  morphOpE     opQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
      opQ     <= OP_SHRINK;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_RUN;
            stepCnt <= '0;
            opQ     <= opSel;
          end
        end
        default: begin
          if (stepCnt == LAST_STEP) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            stepCnt <= stepCnt + CW'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.winClear  = (state == ST_IDLE) && startReq;
    strobe.winShift  = (state == ST_RUN);
    strobe.fillValid = (state == ST_RUN) && (stepCnt < ROW_LIMIT);
    strobe.rowWrite  = (state == ST_RUN) && (stepCnt >= FILL_STEPS);
    wrIdx            = stepCnt - FILL_STEPS;
  end

  assign rdRow     = stepCnt[RW-1:0];
  assign wrRow     = wrIdx[RW-1:0];
  assign busy      = (state == ST_RUN);
  assign passDone  = doneQ;
  assign opLatched = opQ;

  // R8: done is a single-cycle pulse, raised only when idle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> !busy);

  // R9: a start during a pass does not restart the step count
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && stepCnt != LAST_STEP) |=> (stepCnt == $past(stepCnt) + CW'(1)));

  // R11: captured operation holds for the whole pass
  assert_op_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepCnt != LAST_STEP) |=> $stable(opLatched));

endmodule

// File: rtl/morphCell.sv
module morphCell
  import morphPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    winClear,
  input  logic    winShift,
  input  logic    lowerIn,
  input  logic    leftCur,
  input  logic    rightCur,
  input  morphOpE opSel,
  output logic    curBit,
  output logic    resultBit
);

  logic aboveQ, curQ, belowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aboveQ <= 1'b0;
      curQ   <= 1'b0;
      belowQ <= 1'b0;
    end else if (winClear) begin
      aboveQ <= 1'b0;
      curQ   <= 1'b0;
      belowQ <= 1'b0;
    end else if (winShift) begin
      aboveQ <= curQ;
      curQ   <= belowQ;
      belowQ <= lowerIn;
    end
  end

  always_comb begin
    if (opSel == OP_EXPAND)
      resultBit = curQ | aboveQ | belowQ | leftCur | rightCur;
    else
      resultBit = curQ & aboveQ & belowQ & leftCur & rightCur;
  end

  assign curBit = curQ;

  // R3: shrinking never creates a pixel
  assert_shrink_subset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_SHRINK && resultBit) |-> curBit);
  // R4: expanding never removes a pixel
  assert_expand_superset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_EXPAND && curBit) |-> resultBit);

endmodule

// File: rtl/morphData.sv
module morphData
  import morphPkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  morphStrobeT     strobe,
  input  logic [RW-1:0]   rdRow,
  input  logic [RW-1:0]   wrRow,
  input  logic            busy,
  input  morphOpE         opSel,
  input  logic            loadEn,
  input  logic [RW-1:0]   loadRow,
  input  logic [COLS-1:0] loadData,
  input  logic [RW-1:0]   peekRow,
  output logic [COLS-1:0] peekData
);

  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

  logic [COLS-1:0] flagMem [0:ROWS-1];
  logic [COLS-1:0] lowerRow;
  logic [COLS-1:0] curRow;
  logic [COLS-1:0] resultRow;
  logic [ROWS*COLS-1:0] memFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) flagMem[r] <= '0;
    end else if (strobe.rowWrite) begin
      flagMem[wrRow] <= resultRow;
    end else if (loadEn && !busy && loadRow <= ROW_MAX) begin
      flagMem[loadRow] <= loadData;
    end
  end

  always_comb begin
    lowerRow = '0;
    if (strobe.fillValid) lowerRow = flagMem[rdRow];
    peekData = '0;
    if (peekRow <= ROW_MAX) peekData = flagMem[peekRow];
    for (int r = 0; r < ROWS; r++) memFlat[r*COLS +: COLS] = flagMem[r];
  end

  for (genvar c = 0; c < COLS; c++) begin : gCol
    logic leftNb, rightNb;
    if (c == 0) begin : gLeftEdge
      assign leftNb = 1'b0;
    end else begin : gLeftIn
      assign leftNb = curRow[c-1];
    end
    if (c == COLS - 1) begin : gRightEdge
      assign rightNb = 1'b0;
    end else begin : gRightIn
      assign rightNb = curRow[c+1];
    end

    morphCell uCell (
      .clk      (clk),
      .rstN     (rstN),
      .winClear (strobe.winClear),
      .winShift (strobe.winShift),
      .lowerIn  (lowerRow[c]),
      .leftCur  (leftNb),
      .rightCur (rightNb),
      .opSel    (opSel),
      .curBit   (curRow[c]),
      .resultBit(resultRow[c])
    );
  end

  // R10: during the fill cycles of a pass nothing reaches the store
  assert_load_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.rowWrite) |=> $stable(memFlat));

endmodule

// File: rtl/morphEngine.sv
module morphEngine
  import morphPkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            opExpand,
  input  logic            loadEn,
  input  logic [RW-1:0]   loadRow,
  input  logic [COLS-1:0] loadData,
  input  logic [RW-1:0]   peekRow,
  output logic [COLS-1:0] peekData,
  output logic            busy,
  output logic            passDone
);

  morphStrobeT   strobe;
  logic [RW-1:0] rdRow, wrRow;
  morphOpE       opReq, opLatched;

  assign opReq = opExpand ? OP_EXPAND : OP_SHRINK;

  morphCtrl #(.ROWS(ROWS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .opSel    (opReq),
    .strobe   (strobe),
    .rdRow    (rdRow),
    .wrRow    (wrRow),
    .busy     (busy),
    .passDone (passDone),
    .opLatched(opLatched)
  );

  morphData #(.COLS(COLS), .ROWS(ROWS)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdRow   (rdRow),
    .wrRow   (wrRow),
    .busy    (busy),
    .opSel   (opLatched),
    .loadEn  (loadEn),
    .loadRow (loadRow),
    .loadData(loadData),
    .peekRow (peekRow),
    .peekData(peekData)
  );

endmodule

// File: tb/sim_morphEngine.sv
module sim_morphEngine;

  localparam int COLS = 10;
  localparam int ROWS = 6;
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic opExpand = 1'b0;
  logic loadEn = 1'b0;
  logic [RW-1:0] loadRow = '0;
  logic [COLS-1:0] loadData = '0;
  logic [RW-1:0] peekRow = '0;
  logic [COLS-1:0] peekData;
  logic busy, passDone;

  always #2 clk = ~clk;

  morphEngine #(.COLS(COLS), .ROWS(ROWS)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opExpand(opExpand),
    .loadEn(loadEn), .loadRow(loadRow), .loadData(loadData),
    .peekRow(peekRow), .peekData(peekData), .busy(busy), .passDone(passDone)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curTag = "R1";

  // behavioural reference
  logic [COLS-1:0] mImg [ROWS];
  logic [COLS-1:0] mSnap [ROWS];
  bit mBusy, mDone, mOp;
  int mStep;

  function automatic logic pix(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0;
    return mSnap[r][c];
  endfunction

  function automatic logic [COLS-1:0] calcRow(int r);
    logic [COLS-1:0] res;
    for (int c = 0; c < COLS; c++) begin
      logic a, b, l, rt, s;
      a = pix(r-1, c); b = pix(r+1, c); l = pix(r, c-1); rt = pix(r, c+1); s = pix(r, c);
      res[c] = mOp ? (a | b | l | rt | s) : (a & b & l & rt & s);
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) mImg[r] = '0;
      mBusy = 0; mDone = 0; mStep = 0; mOp = 0;
    end else if (mBusy) begin
      if (mStep >= 2) mImg[mStep-2] = calcRow(mStep-2);
      if (mStep == ROWS + 1) begin mBusy = 0; mDone = 1; end
      else begin mStep++; mDone = 0; end
    end else begin
      mDone = 0;
      if (loadEn && loadRow < ROWS) mImg[loadRow] = loadData;
      if (startReq) begin
        mBusy = 1; mStep = 0; mOp = opExpand;
        for (int r = 0; r < ROWS; r++) mSnap[r] = mImg[r];
      end
    end
  end

  task automatic check(string tag, logic [COLS-1:0] act, logic [COLS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // one cycle: compare at the falling edge, then sweep the peek row
  task automatic cyc();
    @(negedge clk);
    check("R7 busy", COLS'(busy), COLS'(mBusy));
    check("R8 passDone", COLS'(passDone), COLS'(mDone));
    check({curTag, " peekData"}, peekData, mImg[peekRow]);
    peekRow = (int'(peekRow) == ROWS - 1) ? '0 : peekRow + 1'b1;
  endtask

  task automatic loadOne(int r, logic [COLS-1:0] v);
    loadEn = 1'b1; loadRow = RW'(r); loadData = v;
    cyc();
    loadEn = 1'b0;
  endtask

  // mode: 0 plain, 1 start mid-pass, 2 load mid-pass, 3 op flip mid-pass
  task automatic runPass(bit op, int mode);
    opExpand = op; startReq = 1'b1;
    cyc();
    startReq = 1'b0;
    for (int k = 0; k < ROWS + 4; k++) begin
      if (k == 2) begin
        if (mode == 1) startReq = 1'b1;
        if (mode == 2) begin loadEn = 1'b1; loadRow = RW'(1); loadData = '1; end
        if (mode == 3) opExpand = ~op;
      end
      cyc();
      startReq = 1'b0; loadEn = 1'b0;
    end
    opExpand = 1'b0;
  endtask

  task automatic clearImg();
    for (int r = 0; r < ROWS; r++) loadOne(r, '0);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1: idle and empty after reset
    curTag = "R1";
    check("R1 busy", COLS'(busy), '0);
    check("R1 passDone", COLS'(passDone), '0);
    for (int r = 0; r < ROWS; r++) begin
      peekRow = RW'(r); #1;
      check("R1 row", peekData, '0);
    end
    peekRow = '0;

    // R2: row loads and peek
    curTag = "R2";
    for (int r = 0; r < ROWS; r++) loadOne(r, COLS'(r * 37 + 5));
    for (int r = 0; r < ROWS; r++) begin
      peekRow = RW'(r); #1;
      check("R2 loaded row", peekData, COLS'(r * 37 + 5));
    end

    // R3: shrink a filled rectangle
    curTag = "R3";
    clearImg();
    for (int r = 1; r <= 4; r++) loadOne(r, 10'b0011111100);
    runPass(1'b0, 0);
    peekRow = RW'(2); #1;
    check("R3 rect row2", peekData, 10'b0001111000);

    // R4 and R6: expand a single pixel; old values only, no diagonal spread
    curTag = "R6";
    clearImg();
    loadOne(2, 10'b0000010000);
    runPass(1'b1, 0);
    peekRow = RW'(3); #1;
    check("R6 row3", peekData, 10'b0000010000);
    peekRow = RW'(2); #1;
    check("R4 row2", peekData, 10'b0000111000);

    // R5: outside pixels are 0
    curTag = "R5";
    for (int r = 0; r < ROWS; r++) loadOne(r, '1);
    runPass(1'b0, 0);
    peekRow = '0; #1;
    check("R5 top row", peekData, '0);
    peekRow = RW'(1); #1;
    check("R5 side cols", peekData, 10'b0111111110);
    clearImg();
    loadOne(0, 10'b0000000001);
    runPass(1'b1, 0);
    peekRow = '0; #1;
    check("R5 corner", peekData, 10'b0000000011);

    // R9, R10, R11: disturbances mid-pass
    curTag = "R9";
    for (int r = 0; r < ROWS; r++) loadOne(r, COLS'($urandom));
    runPass(1'b0, 1);
    curTag = "R10";
    for (int r = 0; r < ROWS; r++) loadOne(r, COLS'($urandom) | 10'b0001111000);
    runPass(1'b1, 2);
    curTag = "R11";
    for (int r = 0; r < ROWS; r++) loadOne(r, COLS'($urandom) | COLS'($urandom));
    runPass(1'b0, 3);

    // R3/R4: repeated passes on random images
    for (int t = 0; t < 6; t++) begin
      curTag = (t % 2 == 1) ? "R4" : "R3";
      for (int r = 0; r < ROWS; r++) loadOne(r, COLS'($urandom) | COLS'($urandom));
      runPass(t[0], 0);
      runPass(t[0], 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule